// File: doc/BRIEF.md
# Crystal Drift Calibrator for a One-Second Timebase

This block divides a real-time crystal enable (nominally 32.768 kHz, presented as a one-cycle enable in the system clock domain) down to a one-second tick. Once a minute it corrects the timebase by a signed number of crystal pulses held in a software-written calibration word. A positive word lengthens one second by that many pulses. A negative word shortens it by that many pulses. A zero word leaves every second at exactly 2^PRE_W pulses, which is 32768 with the default parameters.

A minute-boundary pulse from the surrounding clock logic samples the calibration word and arms the correction. The correction is applied to the single second that begins at the first tick at or after that pulse. Software writes to the calibration word between boundaries have no effect until the next boundary pulse. A 10-bit word reaches ±512 pulses per minute, which is about 260 ppm at 32.768 kHz.

The tick is registered. It appears one system clock after the edge that sampled the last crystal enable of the second.

Top module: `rtc_drift_cal`

## Requirements
- R1: While reset is asserted, and after it is released, `sec_tick` is low, no correction is pending, and the first second lasts the nominal 2^PRE_W pulses.
- R2: With no boundary pulse, every second lasts exactly 2^PRE_W crystal enables. `sec_tick` is a single-cycle pulse, high in the clock after the edge that samples the final enable.
- R3: Cycles in which `xtal_en` is low do not advance the divider. With enables every third clock, a second spans exactly 3·2^PRE_W clocks.
- R4: A positive calibration value N, sampled by a boundary pulse, makes the corrected second last 2^PRE_W + N pulses.
- R5: A negative calibration value −M, sampled by a boundary pulse, makes the corrected second last 2^PRE_W − M pulses.
- R6: `cal_word` is sampled only on a cycle with `minute_mark` high. A change of `cal_word` at any other time does not alter any second's length.
- R7: A boundary pulse corrects exactly one second: the second starting at the first tick at or after the pulse. All later seconds are nominal.
- R8: A boundary pulse in the same cycle as the final enable of a second corrects the second that starts at that tick.
- R9: `cal_word` is two's complement over CAL_W bits. The extremes −2^(CAL_W−1) and 2^(CAL_W−1)−1 give seconds of 2^PRE_W − 512 and 2^PRE_W + 511 pulses (CAL_W=10). The divider never exceeds its terminal count, and a second never ends below 1 pulse.
- R10: When two boundary pulses arrive before the correction is applied, the value sampled by the later pulse is used.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| xtal_en | input | 1 | One-cycle enable per crystal period |
| cal_word | input | CAL_W | Signed pulse correction per minute |
| minute_mark | input | 1 | Minute boundary pulse; samples `cal_word` and arms a correction |
| sec_tick | output | 1 | Corrected one-second tick, one cycle wide |

## Verification
Each result falls due at a fixed point relative to its stimulus:
- **Tick timing:** `sec_tick` is due one clock after the rising edge that samples the final crystal enable of a second.
- **Corrections:** a boundary pulse changes the length of the second that starts at the next tick, or at the same tick when the two coincide.

A behavioural pulse-length model in the bench advances on every rising edge from the same sampled inputs. Its expected tick is compared with the output at every falling edge, so both sides have settled. Second lengths are also measured as crystal-enable counts between observed ticks and checked against the expected value for each scenario.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;
  // Default divider width: 2**15 pulses per nominal second.
  localparam int unsigned DEF_PRE_W = 15;
  // Default calibration word width (signed pulses per minute).
  localparam int unsigned DEF_CAL_W = 10;
  // Stages of the reset release synchronizer.
  localparam int unsigned RST_STAGES = 2;

  typedef enum logic [1:0] {
    ADJ_IDLE    = 2'b00,
    ADJ_ARMED   = 2'b01,
    ADJ_APPLIED = 2'b10
  } adj_state_e;
endpackage

// File: rtl/rtc_rst_sync.sv
module rtc_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  generate
    if (STAGES == 1) begin : g_one
      assign sync_d = 1'b1;
    end else begin : g_many
      assign sync_d = {sync_q[STAGES-2:0], 1'b1};
    end
  endgenerate

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= sync_d;
  end

  assign srst_n = sync_q[STAGES-1];
endmodule

// File: rtl/rtc_cal_capture.sv
// Samples the calibration word at a minute boundary and holds the pending
// correction until the next second boundary consumes it.
module rtc_cal_capture
  import rtc_cal_pkg::*;
#(
  parameter int unsigned CAL_W = DEF_CAL_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mark_i,
  input  logic [CAL_W-1:0] cal_i,
  input  logic             sec_end_i,
  output logic             apply_o,
  output logic [CAL_W-1:0] apply_cal_o
);
  adj_state_e       st_q, st_d;
  logic [CAL_W-1:0] cal_q, cal_d;
  logic             pend;

  assign pend = (st_q == ADJ_ARMED);

  always_comb begin
    st_d  = st_q;
    cal_d = cal_q;
    if (mark_i) begin
      cal_d = cal_i;
      st_d  = sec_end_i ? ADJ_APPLIED : ADJ_ARMED;
    end else if (sec_end_i) begin
      st_d = pend ? ADJ_APPLIED : ADJ_IDLE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ADJ_IDLE;
      cal_q <= '0;
    end else begin
      st_q  <= st_d;
      cal_q <= cal_d;
    end
  end

  assign apply_o     = sec_end_i && (pend || mark_i);
  assign apply_cal_o = mark_i ? cal_i : cal_q;

  // R7: a consumed correction never stays armed.
  assert_pend_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    sec_end_i |=> (st_q != ADJ_ARMED));
  // R6: the held value only changes on a boundary pulse.
  assert_cal_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !mark_i |=> $stable(cal_q));
  // R10: a later boundary pulse replaces the held value.
  assert_last_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
    mark_i |=> (cal_q == $past(cal_i)));
endmodule

// File: rtl/rtc_cal_term.sv
// Chooses the terminal count of the second that is about to start.
module rtc_cal_term
  import rtc_cal_pkg::*;
#(
  parameter int unsigned PRE_W = DEF_PRE_W,
  parameter int unsigned CAL_W = DEF_CAL_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sec_end_i,
  input  logic               apply_i,
  input  logic [CAL_W-1:0]   apply_cal_i,
  output logic [PRE_W:0]     term_o
);
  localparam int unsigned TW    = PRE_W + 1;
  localparam logic [TW-1:0] NOM_T = TW'((2 ** PRE_W) - 1);

  logic [TW-1:0] cal_ext;
  logic [TW-1:0] term_q, term_d;

  assign cal_ext = {{(TW-CAL_W){apply_cal_i[CAL_W-1]}}, apply_cal_i};

  always_comb begin
    term_d = term_q;
    if (sec_end_i) begin
      term_d = apply_i ? (NOM_T + cal_ext) : NOM_T;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) term_q <= NOM_T;
    else        term_q <= term_d;
  end

  assign term_o = term_q;

  // R7: the terminal count changes only at a second boundary.
  assert_term_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !sec_end_i |=> $stable(term_q));
  // R9: a second never ends below one pulse.
  assert_term_floor_R9: assert property (@(posedge clk) disable iff (!rst_n)
    term_q != '0);
endmodule

// File: rtl/rtc_cal_prescaler.sv
// Counts crystal enables up to the current terminal count.
module rtc_cal_prescaler
  import rtc_cal_pkg::*;
#(
  parameter int unsigned PRE_W = DEF_PRE_W
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           xtal_en_i,
  input  logic [PRE_W:0] term_i,
  output logic           sec_end_o,
  output logic           tick_o
);
  localparam int unsigned TW = PRE_W + 1;

  logic [TW-1:0] cnt_q, cnt_d;
  logic          tick_q;
  logic          at_term;

  assign at_term   = (cnt_q == term_i);
  assign sec_end_o = xtal_en_i && at_term;

  always_comb begin
    cnt_d = cnt_q;
    if (xtal_en_i) begin
      cnt_d = at_term ? '0 : (cnt_q + 1'b1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      tick_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      tick_q <= sec_end_o;
    end
  end

  assign tick_o = tick_q;

  // R9: the counter never passes the terminal count chosen by its neighbour.
  assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= term_i);
  // R3: idle crystal cycles leave the divider untouched.
  assert_idle_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !xtal_en_i |=> $stable(cnt_q));
endmodule

// File: rtl/rtc_drift_cal.sv
module rtc_drift_cal
  import rtc_cal_pkg::*;
#(
  parameter int unsigned PRE_W = DEF_PRE_W,
  parameter int unsigned CAL_W = DEF_CAL_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             xtal_en,
  input  logic [CAL_W-1:0] cal_word,
  input  logic             minute_mark,
  output logic             sec_tick
);
  logic             srst_n;
  logic             sec_end;
  logic             apply;
  logic [CAL_W-1:0] apply_cal;
  logic [PRE_W:0]   term;

  rtc_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  rtc_cal_capture #(.CAL_W(CAL_W)) u_capture (
    .clk         (clk),
    .rst_n       (srst_n),
    .mark_i      (minute_mark),
    .cal_i       (cal_word),
    .sec_end_i   (sec_end),
    .apply_o     (apply),
    .apply_cal_o (apply_cal)
  );

  rtc_cal_term #(.PRE_W(PRE_W), .CAL_W(CAL_W)) u_term (
    .clk         (clk),
    .rst_n       (srst_n),
    .sec_end_i   (sec_end),
    .apply_i     (apply),
    .apply_cal_i (apply_cal),
    .term_o      (term)
  );

  rtc_cal_prescaler #(.PRE_W(PRE_W)) u_prescaler (
    .clk       (clk),
    .rst_n     (srst_n),
    .xtal_en_i (xtal_en),
    .term_i    (term),
    .sec_end_o (sec_end),
    .tick_o    (sec_tick)
  );

  // R2: the tick is a single-cycle pulse.
  assert_tick_pulse_R2: assert property (@(posedge clk) disable iff (!srst_n)
    sec_tick |=> !sec_tick);
  // R1: no tick while the internal reset is held.
  assert_reset_quiet_R1: assert property (@(posedge clk)
    !srst_n |-> !sec_tick);
endmodule

// File: tb/rtc_drift_cal_bench.sv
module rtc_drift_cal_bench;
  localparam int PRE_W = 11;
  localparam int CAL_W = 10;
  localparam int NOM   = 2 ** PRE_W;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             xtal_en = 1'b0;
  logic [CAL_W-1:0] cal_word = '0;
  logic             minute_mark = 1'b0;
  logic             sec_tick;

  int n_chk = 0, n_fail = 0;
  int xmode = 3;
  int cyc = 0;
  logic [15:0] lfsr = 16'hACE1;

  // reference model state
  int  m_seen, m_len, m_cal;
  bit  m_pend, m_tick;
  // measurement state
  int  pulse_total = 0, base = 0, last_len = 0, tick_cnt = 0;
  int  last_tick_cyc = 0, last_span = 0;

  rtc_drift_cal #(.PRE_W(PRE_W), .CAL_W(CAL_W)) u_rtc_drift_cal (
    .clk(clk), .rst_n(rst_n), .xtal_en(xtal_en), .cal_word(cal_word),
    .minute_mark(minute_mark), .sec_tick(sec_tick)
  );

  always #2 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_report();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  // behavioural model: lengths of seconds in pulses
  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      m_seen = 0; m_len = NOM; m_pend = 0; m_cal = 0; m_tick = 0;
    end else begin
      m_tick = 0;
      if (xtal_en) pulse_total++;
      if (xtal_en && (m_seen + 1 == m_len)) begin
        m_tick = 1;
        m_seen = 0;
        if (minute_mark)  m_len = NOM + $signed(cal_word);
        else if (m_pend)  m_len = NOM + m_cal;
        else              m_len = NOM;
        m_pend = 0;
      end else begin
        if (xtal_en) m_seen++;
        if (minute_mark) begin
          m_pend = 1;
          m_cal  = $signed(cal_word);
        end
      end
    end
  end

  // compare every clock, measure seconds, drive crystal enable
  always @(negedge clk) begin
    if (rst_n) begin
      chk(sec_tick === m_tick, "R2 per-cycle tick", int'(sec_tick), int'(m_tick));
      if (sec_tick) begin
        last_len = pulse_total - base;
        base = pulse_total;
        last_span = cyc - last_tick_cyc;
        last_tick_cyc = cyc;
        tick_cnt++;
      end
    end
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    case (xmode)
      0: xtal_en = 1'b1;
      1: xtal_en = (cyc % 3 == 0);
      2: xtal_en = lfsr[0] | lfsr[3];
      default: xtal_en = 1'b0;
    endcase
  end

  initial begin
    repeat (190000) @(posedge clk);
    chk(1'b0, "watchdog", cyc, 190000);
    finish_report();
  end

  task automatic next_len(output int len);
    int tc;
    tc = tick_cnt;
    while (tick_cnt == tc) begin
      @(negedge clk); #1;
    end
    len = last_len;
  endtask

  task automatic mark(input int cal);
    @(negedge clk); #1;
    cal_word = CAL_W'(cal);
    minute_mark = 1'b1;
    @(negedge clk); #1;
    minute_mark = 1'b0;
  endtask

  task automatic expect_len(input string req, input int exp);
    int l;
    next_len(l);
    chk(l == exp, req, l, exp);
  endtask

  initial begin
    int l;
    repeat (4) @(negedge clk);
    chk(sec_tick === 1'b0, "R1 tick low in reset", int'(sec_tick), 0);
    #1 rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk(sec_tick === 1'b0, "R1 tick low after reset", int'(sec_tick), 0);
    #1 xmode = 0;
    // R1: first second nominal
    expect_len("R1 first second", NOM);
    // R2/R6: word changed without a boundary pulse has no effect
    cal_word = CAL_W'(37);
    expect_len("R2 nominal", NOM);
    expect_len("R6 no mark no effect", NOM);
    // R3: sparse enables
    xmode = 1;
    expect_len("R3 pulses", NOM);
    expect_len("R3 pulses", NOM);
    chk(last_span == 3 * NOM, "R3 span", last_span, 3 * NOM);
    xmode = 0;
    expect_len("R3 back to dense", NOM);
    // R4 positive
    mark(100);
    expect_len("R4 current second untouched", NOM);
    expect_len("R4 lengthened", NOM + 100);
    expect_len("R7 one second only", NOM);
    // R5 negative
    mark(-200);
    expect_len("R5 current second untouched", NOM);
    expect_len("R5 shortened", NOM - 200);
    expect_len("R7 after negative", NOM);
    // R6 sampled at boundary
    mark(50);
    cal_word = CAL_W'(-7);
    expect_len("R6 current", NOM);
    expect_len("R6 sampled value", NOM + 50);
    expect_len("R6 later nominal", NOM);
    // R10 later pulse wins
    mark(10);
    mark(20);
    expect_len("R10 current", NOM);
    expect_len("R10 later value", NOM + 20);
    // R8 coincident boundary
    next_len(l);
    chk(l == NOM, "R8 setup", l, NOM);
    repeat (NOM - 1) @(negedge clk);
    #1 cal_word = CAL_W'(5); minute_mark = 1'b1;
    @(negedge clk); #1 minute_mark = 1'b0;
    chk(last_len == NOM, "R8 ending second", last_len, NOM);
    expect_len("R8 corrected second", NOM + 5);
    expect_len("R8 then nominal", NOM);
    // R9 extremes
    mark(-512);
    expect_len("R9 current", NOM);
    expect_len("R9 most negative", NOM - 512);
    mark(511);
    expect_len("R9 current", NOM);
    expect_len("R9 most positive", NOM + 511);
    // R9/R3 irregular enables
    xmode = 2;
    mark(-1);
    expect_len("R9 irregular current", NOM);
    expect_len("R9 irregular minus one", NOM - 1);
    expect_len("R7 irregular nominal", NOM);
    // R1 reset mid-second
    xmode = 3;
    @(negedge clk); #1 rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(sec_tick === 1'b0, "R1 tick low in second reset", int'(sec_tick), 0);
    #1 rst_n = 1'b1;
    base = pulse_total;
    repeat (5) @(negedge clk);
    #1 xmode = 0;
    expect_len("R1 nominal after reset", NOM);
    finish_report();
  end
endmodule